// File: doc/BRIEF.md
# Page-Bounded Stride Stream Prefetcher

This block sits beside a data cache and watches the demand load stream, one cache-line address per cycle. It keeps a small, fully associative table of the 4 KiB pages touched most recently. For each page it stores the line slot that was touched last. When a page that is already tracked is touched again at a different line, the signed distance between the new line and the stored one is taken as a stride. The block then proposes up to two lines further along that stride, starting from the new line. A proposal that would leave the page is discarded. A positive distance drives the page's forward stream and a negative one drives its backward stream, so each tracked page carries at most two streams.

Proposed lines go into a small request queue that drains through a valid/ready port. A held request stays stable until it is accepted. The demand side has no back-pressure. When the queue has no room, new proposals are discarded, so a stalled consumer never stalls demand traffic. When one access yields two proposals and only one slot is free, the nearer line is kept.

Top module: `pgstride_pf`

## Requirements
- R1: A line address is split into a page number (upper 20 bits) and a 6-bit line slot (lower bits), giving 64 slots per page. Each issued request carries the page of the access that produced it, with the target slot in the lower 6 bits.
- R2: The first access to an untracked page issues no request.
- R3: An access to a tracked page at a slot above the stored slot forms a forward stride s = new - stored. It issues new+s and then new+2s, in that order.
- R4: An access at a slot below the stored slot forms a backward stride, which is negative. Its targets are computed with the same rule.
- R5: A target below slot 0 or above slot 63 is dropped. If the far target leaves the page and the near one does not, only the near target is issued.
- R6: The table tracks 16 pages and replaces the least recently used one. A page revisited after 15 other distinct pages is still tracked. A page revisited after 16 other distinct pages has been evicted and is treated as new.
- R7: Every later access to a tracked page measures its stride from the most recent slot of that page, not from any older slot.
- R8: The request queue holds 4 entries. Proposals that find no free slot are dropped. The demand input is never stalled. While pf_valid is high and pf_ready is low, pf_line stays unchanged.
- R9: A synchronous active-high reset empties the queue, so pf_valid is low on the next cycle. It also forgets every tracked page.
- R10: A repeated access to the slot already stored for that page issues no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmd_valid | input | 1 | A demand access is present this cycle |
| dmd_line | input | 26 | Demand cache-line address (byte address without its 6 low bits) |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer accepts the offered request this cycle |
| pf_line | output | 26 | Cache-line address of the offered prefetch |

## Verification
On every cycle the assertions check four things. At most one table entry matches the incoming page. Misses and idle cycles propose nothing. Every proposal stays in the demand page and differs from the demand slot. Queue occupancy never exceeds the depth, and a held request stays stable under back-pressure. The bench scenarios are what show that the projected slots have the right values, that page-edge clipping works, that the LRU eviction point is exactly 16 pages, that the queue drops proposals once full, and that reset makes the table forget its pages.

// File: rtl/pgstride_pkg.sv
package pgstride_pkg;

  // classification of one demand access against the page table
  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,  // no access this cycle
    ACC_ALLOC  = 2'd1,  // page not tracked, entry allocated
    ACC_STEP   = 2'd2,  // tracked page, non-zero stride
    ACC_REPEAT = 2'd3   // tracked page, same slot again
  } acc_kind_t;

  localparam int unsigned PF_ADDR_W_DEF     = 32;
  localparam int unsigned PF_PAGE_SHIFT_DEF = 12;
  localparam int unsigned PF_LINE_SHIFT_DEF = 6;

endpackage

// File: rtl/pgstride_table.sv
module pgstride_table
  import pgstride_pkg::*;
#(
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned ENTRIES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [TAG_W-1:0]        req_tag,
  input  logic [IDX_W-1:0]        req_idx,
  output logic [ENTRIES-1:0]      hit_vec,
  output acc_kind_t               kind,
  output logic signed [IDX_W:0]   stride
);

  localparam int unsigned AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] last;
    logic [AGE_W-1:0] age;
  } ent_t;

  ent_t             ent [ENTRIES];
  logic [ENTRIES-1:0] old_vec;
  logic             hit_any;
  logic [AGE_W-1:0] hit_sel;
  logic [AGE_W-1:0] vic_sel;
  logic [AGE_W-1:0] sel;
  logic [AGE_W-1:0] sel_age;
  logic [IDX_W-1:0] last_sel;
  logic signed [IDX_W:0] delta;

  // parallel tag compare and oldest-entry detect
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = ent[i].vld && (ent[i].tag == req_tag);
    assign old_vec[i] = (ent[i].age == OLDEST);
  end

  always_comb begin
    hit_sel = '0;
    vic_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_sel = AGE_W'(i);
      if (old_vec[i]) vic_sel = AGE_W'(i);
    end
  end

  assign hit_any  = |hit_vec;
  assign sel      = hit_any ? hit_sel : vic_sel;
  assign sel_age  = ent[sel].age;
  assign last_sel = ent[hit_sel].last;
  assign delta    = $signed({1'b0, req_idx}) - $signed({1'b0, last_sel});
  assign stride   = delta;

  always_comb begin
    if (!req_valid)       kind = ACC_IDLE;
    else if (!hit_any)    kind = ACC_ALLOC;
    else if (delta == '0) kind = ACC_REPEAT;
    else                  kind = ACC_STEP;
  end

  // ages always form a permutation; untouched (invalid) entries stay oldest
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent[i].vld  <= 1'b0;
        ent[i].tag  <= '0;
        ent[i].last <= '0;
        ent[i].age  <= AGE_W'(i);
      end
    end else if (req_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (AGE_W'(i) == sel)          ent[i].age <= '0;
        else if (ent[i].age < sel_age) ent[i].age <= ent[i].age + 1'b1;
      end
      if (!hit_any) begin
        ent[sel].vld  <= 1'b1;
        ent[sel].tag  <= req_tag;
        ent[sel].last <= req_idx;
      end else if (kind == ACC_STEP) begin
        ent[sel].last <= req_idx;
      end
    end
  end

endmodule

// File: rtl/pgstride_proj.sv
module pgstride_proj #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DEGREE = 2
) (
  input  logic                          fire,
  input  logic [IDX_W-1:0]              base,
  input  logic signed [IDX_W:0]         stride,
  output logic [DEGREE-1:0]             tgt_ok,
  output logic [DEGREE-1:0][IDX_W-1:0]  tgt_idx
);

  localparam int unsigned PW = IDX_W + 3;

  logic signed [PW-1:0] base_x;
  logic signed [PW-1:0] step_x;

  assign base_x = $signed({3'b000, base});
  assign step_x = {{2{stride[IDX_W]}}, stride};

  for (genvar k = 0; k < DEGREE; k++) begin : g_tgt
    logic signed [PW-1:0] t;
    assign t          = base_x + step_x * $signed(PW'(k + 1));
    // inside the page only when non-negative and below 2**IDX_W
    assign tgt_ok[k]  = fire && !t[PW-1] && (t[PW-2:IDX_W] == '0);
    assign tgt_idx[k] = t[IDX_W-1:0];
  end

endmodule

// File: rtl/pgstride_fifo.sv
module pgstride_fifo #(
  parameter int unsigned W      = 26,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned PUSH_N = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PUSH_N-1:0]        push_req,
  input  logic [PUSH_N-1:0][W-1:0] push_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [W-1:0]             out_data,
  output logic [CNT_W-1:0]         fill
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] room;
  logic [CNT_W-1:0] taken;
  logic [PUSH_N-1:0] acc;
  logic [PTR_W-1:0] wpos [PUSH_N];
  logic             pop;

  assign room      = CNT_W'(DEPTH) - fill;
  assign out_valid = (fill != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;

  // earlier push lanes take free slots first; the rest are dropped
  always_comb begin
    taken = '0;
    for (int k = 0; k < PUSH_N; k++) begin
      acc[k]  = 1'b0;
      wpos[k] = wr_ptr + PTR_W'(taken);
      if (push_req[k] && (taken < room)) begin
        acc[k] = 1'b1;
        taken  = taken + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      for (int k = 0; k < PUSH_N; k++) begin
        if (acc[k]) mem[wpos[k]] <= push_data[k];
      end
      wr_ptr <= wr_ptr + PTR_W'(taken);
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      fill <= fill + taken - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/pgstride_pf.sv
module pgstride_pf
  import pgstride_pkg::*;
#(
  parameter int unsigned ADDR_W     = PF_ADDR_W_DEF,
  parameter int unsigned PAGE_SHIFT = PF_PAGE_SHIFT_DEF,
  parameter int unsigned LINE_SHIFT = PF_LINE_SHIFT_DEF,
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned DEGREE     = 2,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dmd_valid,
  input  logic [ADDR_W-LINE_SHIFT-1:0] dmd_line,
  output logic                         pf_valid,
  input  logic                         pf_ready,
  output logic [ADDR_W-LINE_SHIFT-1:0] pf_line
);

  localparam int unsigned LINE_W = ADDR_W - LINE_SHIFT;
  localparam int unsigned IDX_W  = PAGE_SHIFT - LINE_SHIFT;
  localparam int unsigned TAG_W  = LINE_W - IDX_W;
  localparam int unsigned CNT_W  = ((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1) + 1;

  logic [TAG_W-1:0]               dmd_tag;
  logic [IDX_W-1:0]               dmd_idx;
  logic [ENTRIES-1:0]             hit_vec;
  acc_kind_t                      kind;
  logic signed [IDX_W:0]          stride;
  logic [DEGREE-1:0]              push_req;
  logic [DEGREE-1:0][IDX_W-1:0]   tgt_idx;
  logic [DEGREE-1:0][LINE_W-1:0]  push_line;
  logic [CNT_W-1:0]               fifo_cnt;

  assign dmd_tag = dmd_line[LINE_W-1:IDX_W];
  assign dmd_idx = dmd_line[IDX_W-1:0];

  pgstride_table #(
    .TAG_W   (TAG_W),
    .IDX_W   (IDX_W),
    .ENTRIES (ENTRIES)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .req_valid (dmd_valid),
    .req_tag   (dmd_tag),
    .req_idx   (dmd_idx),
    .hit_vec   (hit_vec),
    .kind      (kind),
    .stride    (stride)
  );

  pgstride_proj #(
    .IDX_W  (IDX_W),
    .DEGREE (DEGREE)
  ) u_proj (
    .fire    (kind == ACC_STEP),
    .base    (dmd_idx),
    .stride  (stride),
    .tgt_ok  (push_req),
    .tgt_idx (tgt_idx)
  );

  for (genvar k = 0; k < DEGREE; k++) begin : g_line
    assign push_line[k] = {dmd_tag, tgt_idx[k]};
  end

  pgstride_fifo #(
    .W      (LINE_W),
    .DEPTH  (FIFO_DEPTH),
    .PUSH_N (DEGREE)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .push_data (push_line),
    .out_valid (pf_valid),
    .out_ready (pf_ready),
    .out_data  (pf_line),
    .fill      (fifo_cnt)
  );

endmodule

// File: rtl/pgstride_chk.sv
module pgstride_chk
  import pgstride_pkg::*;
#(
  parameter int unsigned LINE_W     = 26,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned DEGREE     = 2,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = 3
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          dmd_valid,
  input logic [LINE_W-1:0]             dmd_line,
  input logic                          pf_valid,
  input logic                          pf_ready,
  input logic [LINE_W-1:0]             pf_line,
  input logic [ENTRIES-1:0]            hit_vec,
  input acc_kind_t                     kind,
  input logic [DEGREE-1:0]             push_req,
  input logic [DEGREE-1:0][LINE_W-1:0] push_line,
  input logic [CNT_W-1:0]              fifo_cnt
);

  AST_RESET_DRAINS: assert property (@(posedge clk) rst |=> !pf_valid); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line)); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNT_W'(FIFO_DEPTH)); // R8

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R6

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_ALLOC |-> push_req == '0); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dmd_valid |-> push_req == '0); // R3

  for (genvar k = 0; k < DEGREE; k++) begin : g_lane
    AST_PUSH_PAGE: assert property (@(posedge clk) disable iff (rst)
      push_req[k] |-> push_line[k][LINE_W-1:IDX_W] == dmd_line[LINE_W-1:IDX_W]); // R1
    AST_PUSH_NEW_LINE: assert property (@(posedge clk) disable iff (rst)
      push_req[k] |-> push_line[k][IDX_W-1:0] != dmd_line[IDX_W-1:0]); // R10
  end

endmodule

bind pgstride_pf pgstride_chk #(
  .LINE_W     (LINE_W),
  .IDX_W      (IDX_W),
  .ENTRIES    (ENTRIES),
  .DEGREE     (DEGREE),
  .FIFO_DEPTH (FIFO_DEPTH),
  .CNT_W      (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dmd_valid (dmd_valid),
  .dmd_line  (dmd_line),
  .pf_valid  (pf_valid),
  .pf_ready  (pf_ready),
  .pf_line   (pf_line),
  .hit_vec   (hit_vec),
  .kind      (kind),
  .push_req  (push_req),
  .push_line (push_line),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/test_pgstride_pf.sv
module test_pgstride_pf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dmd_valid = 1'b0;
  logic [25:0] dmd_line = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b0;
  logic [25:0] pf_line;

  always #10 clk = ~clk;  // 50 MHz

  pgstride_pf i_pgstride_pf (
    .clk       (clk),
    .rst       (rst),
    .dmd_valid (dmd_valid),
    .dmd_line  (dmd_line),
    .pf_valid  (pf_valid),
    .pf_ready  (pf_ready),
    .pf_line   (pf_line)
  );

  function automatic logic [25:0] ln(input logic [19:0] pg, input int slot);
    return {pg, 6'(slot)};
  endfunction

  // {access line, expected count, first target, second target}
  localparam int NV = 13;
  localparam logic [79:0] VEC [NV] = '{
    {ln(20'h10, 5),  2'd0, 26'd0, 26'd0},                 // R2 first touch
    {ln(20'h10, 9),  2'd2, ln(20'h10, 13), ln(20'h10, 17)}, // R3 stride +4
    {ln(20'h10, 11), 2'd2, ln(20'h10, 13), ln(20'h10, 15)}, // R7 stride +2 from newest
    {ln(20'h20, 40), 2'd0, 26'd0, 26'd0},                 // R2
    {ln(20'h20, 30), 2'd2, ln(20'h20, 20), ln(20'h20, 10)}, // R4 stride -10
    {ln(20'h30, 50), 2'd0, 26'd0, 26'd0},                 // R2
    {ln(20'h30, 58), 2'd0, 26'd0, 26'd0},                 // R5 both above page
    {ln(20'h40, 20), 2'd0, 26'd0, 26'd0},                 // R2
    {ln(20'h40, 40), 2'd1, ln(20'h40, 60), 26'd0},        // R5 far target clipped
    {ln(20'h40, 40), 2'd0, 26'd0, 26'd0},                 // R10 same slot
    {ln(20'h20, 25), 2'd2, ln(20'h20, 20), ln(20'h20, 15)}, // R7 stride -5
    {ln(20'h50, 3),  2'd0, 26'd0, 26'd0},                 // R2
    {ln(20'h50, 1),  2'd0, 26'd0, 26'd0}                  // R5 both below page
  };

  function automatic string vreq(input int v);
    case (v)
      1:       return "R3";
      2, 10:   return "R7";
      4:       return "R4";
      6, 8, 12: return "R5";
      9:       return "R10";
      default: return "R2";
    endcase
  endfunction

  int total = 0;
  int bad   = 0;
  logic [25:0] got [8];
  int got_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [25:0] line);
    @(negedge clk);
    dmd_valid = 1'b1;
    dmd_line  = line;
    @(negedge clk);
    dmd_valid = 1'b0;
  endtask

  task automatic drain(input int cyc);
    got_n    = 0;
    pf_ready = 1'b1;
    repeat (cyc) begin
      if (pf_valid) begin
        got[got_n] = pf_line;
        got_n++;
      end
      @(negedge clk);
    end
    pf_ready = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pf_valid == 1'b0, "R9", "pf_valid in reset", pf_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pf_valid == 1'b0, "R9", "pf_valid after reset", pf_valid, 0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      access(VEC[v][79:54]);
      drain(4);
      chk(got_n == int'(VEC[v][53:52]), vreq(v), "request count", got_n, VEC[v][53:52]);
      if (VEC[v][53:52] >= 2'd1)
        chk(got[0] == VEC[v][51:26], vreq(v), "first target", got[0], VEC[v][51:26]);
      if (VEC[v][53:52] >= 2'd2)
        chk(got[1] == VEC[v][25:0], vreq(v), "second target", got[1], VEC[v][25:0]);
    end

    // R6: evicted after 16 other pages
    access(ln(20'h100, 0));
    for (int k = 0; k < 16; k++) access(ln(20'h200 + 20'(k), 0));
    access(ln(20'h100, 4));
    drain(4);
    chk(got_n == 0, "R6", "revisit after 16 pages", got_n, 0);

    // R6: still tracked after 15 other pages
    access(ln(20'h300, 0));
    for (int k = 0; k < 15; k++) access(ln(20'h400 + 20'(k), 0));
    access(ln(20'h300, 4));
    drain(4);
    chk(got_n == 2, "R6", "revisit after 15 pages count", got_n, 2);
    chk(got[0] == ln(20'h300, 8), "R6", "revisit target", got[0], ln(20'h300, 8));

    // R8: hold under back-pressure, then overflow drops
    access(ln(20'h500, 0));
    access(ln(20'h500, 1));
    chk(pf_valid && pf_line == ln(20'h500, 2), "R8", "head offered", pf_line, ln(20'h500, 2));
    access(ln(20'h500, 2));
    access(ln(20'h500, 3));
    chk(pf_valid && pf_line == ln(20'h500, 2), "R8", "head held", pf_line, ln(20'h500, 2));
    drain(6);
    chk(got_n == 4, "R8", "queue depth kept", got_n, 4);
    chk(got[2] == ln(20'h500, 3), "R8", "third entry", got[2], ln(20'h500, 3));
    chk(got[3] == ln(20'h500, 4), "R8", "fourth entry", got[3], ln(20'h500, 4));

    // R9: reset empties queue and forgets pages
    access(ln(20'h600, 0));
    access(ln(20'h600, 1));
    chk(pf_valid == 1'b1, "R9", "queue loaded", pf_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(pf_valid == 1'b0, "R9", "queue emptied", pf_valid, 0);
    access(ln(20'h600, 2));
    drain(3);
    chk(got_n == 0, "R9", "page forgotten", got_n, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule